// File: doc/BRIEF.md
# Flash Write Encryption Staging Unit

This unit sits on the write path to an external flash device and prepares one 256-bit block of code in encrypted form. Software sets a target flash address, fills eight 32-bit plaintext buffer registers, and launches the operation with a start bit. The unit then derives a per-block key and runs a fixed-latency placeholder cipher. After that it raises a done flag and holds the eight-word result.

When the flash write port later asks for data, the unit checks the request. If a completed result is staged for exactly that address and the global enable is high, the unit returns the staged ciphertext and discards the caller's data. In every other case the caller's data passes through unchanged. A substitution consumes the staged result.

The key starts as a base value built from a coding-scheme field and a 256-bit key block. A configuration word then optionally tweaks it with the block index of the flash address. An all-zero configuration word disables the tweak, so every address then uses the same key.

Top module: `flash_crypt_stage`

## Requirements
- R1: After reset, `done_o`, `err_o`, `wr_valid` and `wr_enc` are 0 and `wr_out` is all zero.
- R2: A register write with `reg_sel` 0 to 7 loads plaintext word `reg_sel`; word 0 occupies plaintext bits 31:0 and word k bits 32k+31:32k. `reg_sel` 8 loads the flash address from `reg_wdata[23:0]`. `reg_sel` 9 with `reg_wdata[0]`=1 is a start request.
- R3: A start request is accepted only when `enc_en` is 1 and `err_o` is 0. `done_o` becomes 1 exactly 8 clock edges after the edge that accepted the start. An ignored start leaves `done_o` unchanged.
- R4: An address write with any of bits 4:0 nonzero sets `err_o`, and an aligned address write clears it. A start issued while `err_o` is 1 never sets `done_o`.
- R5: Ciphertext word i equals plaintext word i XOR key word i XOR (i * 32'h01010101).
- R6: Base key word i equals key block word i (bits 32i+31:32i of `key_blk`) XOR (`coding` * 32'h9E3779B9), truncated to 32 bits.
- R7: With `crypt_cfg` all zero, the working key equals the base key. Otherwise every working key word is the base key word XOR ((address >> 5) * 32'h85EBCA6B) XOR the zero-extended `crypt_cfg`. The key inputs are sampled when the start is accepted.
- R8: `done_o` clears on an accepted start and on any buffer or address write. A buffer or address write during an operation cancels that operation.
- R9: A write-port request is answered one edge later with `wr_valid`=1. If `done_o` was 1, `enc_en` is 1 and `wr_addr` equals the stored address, then `wr_out` carries the staged ciphertext and `wr_enc`=1.
- R10: Otherwise `wr_out` equals the request's `wr_data` and `wr_enc`=0. This covers the cases of no completed operation, a different address, and `enc_en` low.
- R11: A substitution clears `done_o`, so a later request to the same address passes its own data through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_en | input | 1 | Global encryption enable |
| coding | input | 2 | Coding-scheme value for base key |
| key_blk | input | 256 | Key block, word i at bits 32i+31:32i |
| crypt_cfg | input | 4 | Key tweak configuration word |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| done_o | output | 1 | Result staged and ready |
| err_o | output | 1 | Misaligned address stored |
| wr_req | input | 1 | Flash write-port data request |
| wr_addr | input | 24 | Flash address of the request |
| wr_data | input | 256 | Caller-supplied block |
| wr_valid | output | 1 | Response valid |
| wr_out | output | 256 | Block to write to flash |
| wr_enc | output | 1 | Response carries staged ciphertext |

## Verification
The bench keeps the default parameters: a 24-bit address, 8-cycle latency, 2-bit coding field and 4-bit configuration word. With 19 block-index bits, random aligned addresses almost always differ, which makes the per-block tweak visible in every result. With the narrow configuration word, the all-zero case is cheap to force on every fourth pass. The 8-cycle latency gives room to cancel an operation mid-flight with a buffer write and to check that `done_o` is still low one edge before it is due.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int WORD_W    = 32;
  localparam int NWORDS    = 8;
  localparam int BLK_W     = WORD_W * NWORDS;
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int OFS_W     = $clog2(BLK_BYTES);
  localparam int IDX_W     = $clog2(NWORDS);
  localparam int SEL_W     = 4;
  localparam logic [SEL_W-1:0] SEL_ADDR  = 4'd8;
  localparam logic [SEL_W-1:0] SEL_START = 4'd9;
  localparam logic [WORD_W-1:0] CS_MIX  = 32'h9E3779B9;
  localparam logic [WORD_W-1:0] BLK_MIX = 32'h85EBCA6B;
  localparam logic [WORD_W-1:0] IDX_MIX = 32'h01010101;
endpackage

// File: rtl/fcs_keygen.sv
module fcs_keygen
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CS_W   = 2,
  parameter int CFG_W  = 4
) (
  input  logic [BLK_W-1:0]  kblk,
  input  logic [CS_W-1:0]   cs,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  key
);
  logic [WORD_W-1:0] cs_term;
  logic [WORD_W-1:0] tweak;
  logic [ADDR_W-1:0] blk_idx;

  always_comb begin
    blk_idx = addr >> OFS_W;
    cs_term = WORD_W'(cs) * CS_MIX;
    if (cfg == '0) tweak = '0;
    else           tweak = (WORD_W'(blk_idx) * BLK_MIX) ^ WORD_W'(cfg);
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    assign key[i*WORD_W +: WORD_W] = kblk[i*WORD_W +: WORD_W] ^ cs_term ^ tweak;
  end
endmodule

// File: rtl/fcs_cipher.sv
module fcs_cipher
  import fcs_pkg::*;
#(
  parameter int LAT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [BLK_W-1:0] pt,
  input  logic [BLK_W-1:0] key,
  output logic             last,
  output logic [BLK_W-1:0] ct
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] pt_q;
  logic [BLK_W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pt_q   <= '0;
      key_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      pt_q   <= pt;
      key_q  <= key;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(LAT - 1)) busy_q <= 1'b0;
      else                          cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign last = busy_q && (cnt_q == CNT_W'(LAT - 1)) && !abort && !start;

  for (genvar i = 0; i < NWORDS; i++) begin : g_mix
    assign ct[i*WORD_W +: WORD_W] = pt_q[i*WORD_W +: WORD_W] ^ key_q[i*WORD_W +: WORD_W]
                                    ^ (WORD_W'(i) * IDX_MIX);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cnt_q < CNT_W'(LAT)); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy_q); // R8
endmodule

// File: rtl/fcs_wport.sv
module fcs_wport
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             hit,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] staged,
  output logic             valid,
  output logic             enc,
  output logic [BLK_W-1:0] out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      enc   <= 1'b0;
      out   <= '0;
    end else begin
      valid <= req;
      enc   <= req && hit;
      if (req) out <= hit ? staged : data;
    end
  end

  AST_PASS_DATA: assert property (@(posedge clk) disable iff (rst)
    req && !hit |=> out == $past(data) && !enc); // R10
  AST_SWAP_DATA: assert property (@(posedge clk) disable iff (rst)
    req && hit |=> out == $past(staged) && enc); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req |=> valid); // R9
endmodule

// File: rtl/flash_crypt_stage.sv
module flash_crypt_stage
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CS_W   = 2,
  parameter int CFG_W  = 4,
  parameter int LAT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_en,
  input  logic [CS_W-1:0]   coding,
  input  logic [BLK_W-1:0]  key_blk,
  input  logic [CFG_W-1:0]  crypt_cfg,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              done_o,
  output logic              err_o,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BLK_W-1:0]  wr_data,
  output logic              wr_valid,
  output logic [BLK_W-1:0]  wr_out,
  output logic              wr_enc
);
  localparam int AGE_W = $clog2(LAT + 2);

  logic [WORD_W-1:0] buf_q [NWORDS];
  logic [BLK_W-1:0]  pt_flat;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;
  logic              done_q;
  logic [BLK_W-1:0]  staged_q;
  logic [BLK_W-1:0]  key_w;
  logic [BLK_W-1:0]  ct_w;
  logic              last_w;

  logic buf_we, addr_we, start_wr, start_ok, abort, hit, addr_ok;

  always_comb begin
    buf_we   = reg_we && (reg_sel < SEL_W'(NWORDS));
    addr_we  = reg_we && (reg_sel == SEL_ADDR);
    start_wr = reg_we && (reg_sel == SEL_START) && reg_wdata[0];
    start_ok = start_wr && enc_en && !err_q;
    abort    = buf_we || addr_we;
    addr_ok  = (reg_wdata[OFS_W-1:0] == '0);
    hit      = wr_req && done_q && enc_en && (wr_addr == addr_q);
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst)                                                    buf_q[i] <= '0;
      else if (buf_we && reg_sel[IDX_W-1:0] == IDX_W'(i))          buf_q[i] <= reg_wdata;
    end
    assign pt_flat[i*WORD_W +: WORD_W] = buf_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      staged_q <= '0;
    end else begin
      if (addr_we) begin
        addr_q <= reg_wdata[ADDR_W-1:0];
        err_q  <= !addr_ok;
      end
      if (abort || start_ok || hit) done_q <= 1'b0;
      else if (last_w)              done_q <= 1'b1;
      if (last_w) staged_q <= ct_w;
    end
  end

  fcs_keygen #(.ADDR_W(ADDR_W), .CS_W(CS_W), .CFG_W(CFG_W)) i_keygen (
    .kblk (key_blk),
    .cs   (coding),
    .cfg  (crypt_cfg),
    .addr (addr_q),
    .key  (key_w)
  );

  fcs_cipher #(.LAT(LAT)) i_cipher (
    .clk   (clk),
    .rst   (rst),
    .start (start_ok),
    .abort (abort),
    .pt    (pt_flat),
    .key   (key_w),
    .last  (last_w),
    .ct    (ct_w)
  );

  fcs_wport i_wport (
    .clk    (clk),
    .rst    (rst),
    .req    (wr_req),
    .hit    (hit),
    .data   (wr_data),
    .staged (staged_q),
    .valid  (wr_valid),
    .enc    (wr_enc),
    .out    (wr_out)
  );

  assign done_o = done_q;
  assign err_o  = err_q;

  // cycle count since the last accepted start, saturating
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                              age_q <= AGE_W'(LAT + 1);
    else if (start_ok)                    age_q <= '0;
    else if (age_q != AGE_W'(LAT + 1))    age_q <= age_q + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> age_q == AGE_W'(LAT)); // R3
  AST_NO_EN_START: assert property (@(posedge clk) disable iff (rst)
    start_wr && !enc_en && !done_q && !last_w |=> !done_q); // R3
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    err_q && start_wr |=> !done_q); // R4
  AST_DONE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    done_q |-> addr_q[OFS_W-1:0] == '0 && !err_q); // R4
  AST_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    abort |=> !done_q); // R8
  AST_CONSUME: assert property (@(posedge clk) disable iff (rst)
    hit |=> !done_q && wr_enc); // R11
endmodule

// File: tb/test_flash_crypt_stage.sv
`timescale 1ns/1ps
module test_flash_crypt_stage;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enc_en = 1'b1;
  logic [1:0]   coding = '0;
  logic [255:0] key_blk = '0;
  logic [3:0]   crypt_cfg = '0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_sel = '0;
  logic [31:0]  reg_wdata = '0;
  logic         done_o, err_o;
  logic         wr_req = 1'b0;
  logic [23:0]  wr_addr = '0;
  logic [255:0] wr_data = '0;
  logic         wr_valid, wr_enc;
  logic [255:0] wr_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flash_crypt_stage i_flash_crypt_stage (
    .clk(clk), .rst(rst), .enc_en(enc_en), .coding(coding), .key_blk(key_blk),
    .crypt_cfg(crypt_cfg), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .done_o(done_o), .err_o(err_o), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_out(wr_out), .wr_enc(wr_enc)
  );

  function automatic logic [255:0] model_ct(input logic [255:0] pt, input logic [255:0] kb,
      input logic [1:0] cs, input logic [3:0] cfg, input logic [23:0] addr);
    logic [31:0] base_mix, tw;
    logic [255:0] r;
    base_mix = {30'b0, cs} * 32'h9E3779B9;                       // R6
    tw = (cfg == 4'd0) ? 32'h0 : (({13'b0, addr[23:5]} * 32'h85EBCA6B) ^ {28'b0, cfg}); // R7
    for (int i = 0; i < 8; i++)
      r[i*32 +: 32] = pt[i*32 +: 32] ^ kb[i*32 +: 32] ^ base_mix ^ tw ^ (32'(i) * 32'h01010101); // R5
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wreg(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(input logic [23:0] a, input logic [255:0] pt);
    wreg(4'd8, {8'b0, a});
    for (int i = 0; i < 8; i++) wreg(4'(i), pt[i*32 +: 32]);
  endtask

  // start, then check done timing: low one edge before due, high at edge 8
  task automatic start_timed(input string tag);
    wreg(4'd9, 32'd1);
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (j == 7) chk(done_o == 1'b0, tag, {255'b0, done_o}, 256'd0);
      if (j == 8) chk(done_o == 1'b1, tag, {255'b0, done_o}, 256'd1);
    end
  endtask

  task automatic wport(input logic [23:0] a, input logic [255:0] d,
                       output logic [255:0] o, output logic e, output logic v);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    o = wr_out; e = wr_enc; v = wr_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [255:0] pt, d, o, exp, o2;
    logic [23:0]  a;
    logic e, v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_o && !err_o && !wr_valid && !wr_enc && wr_out == '0, "R1 reset state",
        {252'b0, done_o, err_o, wr_valid, wr_enc}, 256'd0);

    // pass-through before any operation
    d = rnd256();
    wport(24'h000100, d, o, e, v);
    chk(o == d && !e && v, "R10 no operation yet", o, d);

    // R2 word order: zero key, zero coding, zero config
    pt = '0; pt[31:0] = 32'hCAFE0001;
    load(24'h000040, pt);
    start_timed("R3 done latency (directed)");
    wport(24'h000040, rnd256(), o, e, v);
    exp = '0; exp[31:0] = 32'hCAFE0001;
    for (int i = 1; i < 8; i++) exp[i*32 +: 32] = 32'(i) * 32'h01010101;
    chk(o == exp && e, "R2 buffer word order", o, exp);

    // random passes
    for (int it = 0; it < 40; it++) begin
      coding  = 2'($urandom);
      key_blk = rnd256();
      crypt_cfg = (it % 4 == 0) ? 4'd0 : 4'($urandom);
      a  = {19'($urandom), 5'b0};
      pt = rnd256();
      load(a, pt);
      start_timed("R3 done latency");
      d = rnd256();
      wport(a ^ 24'h000020, d, o, e, v);
      chk(o == d && !e, "R10 other address passes", o, d);
      chk(done_o, "R10 other address keeps done", {255'b0, done_o}, 256'd1);
      exp = model_ct(pt, key_blk, coding, crypt_cfg, a);
      wport(a, rnd256(), o, e, v);
      chk(o == exp && e && v, "R5 R6 R7 R9 ciphertext swap", o, exp);
      chk(!done_o, "R11 done cleared by swap", {255'b0, done_o}, 256'd0);
      d = rnd256();
      wport(a, d, o, e, v);
      chk(o == d && !e, "R11 repeat passes through", o, d);
    end

    // R7: zero config gives the same key at two addresses
    crypt_cfg = 4'd0; coding = 2'd3; key_blk = rnd256(); pt = rnd256();
    load(24'h012340, pt); start_timed("R3 latency cfg0 a");
    wport(24'h012340, '0, o, e, v);
    load(24'h7FFFE0, pt); start_timed("R3 latency cfg0 b");
    wport(24'h7FFFE0, '0, o2, e, v);
    chk(o == o2, "R7 zero config independent of address", o2, o);
    exp = model_ct(pt, key_blk, 2'd3, 4'd0, 24'h0);
    chk(o == exp, "R6 base key only", o, exp);

    // R4 misaligned address
    wreg(4'd8, 32'h000044);
    chk(err_o, "R4 misaligned sets error", {255'b0, err_o}, 256'd1);
    wreg(4'd9, 32'd1);
    repeat (10) @(negedge clk);
    chk(!done_o, "R4 start ignored on error", {255'b0, done_o}, 256'd0);
    wreg(4'd8, 32'h000060);
    chk(!err_o, "R4 aligned clears error", {255'b0, err_o}, 256'd0);

    // R3 enable low
    enc_en = 1'b0;
    wreg(4'd9, 32'd1);
    repeat (10) @(negedge clk);
    chk(!done_o, "R3 start ignored with enable low", {255'b0, done_o}, 256'd0);
    enc_en = 1'b1;

    // R8 clears
    start_timed("R3 latency before clear");
    wreg(4'd3, 32'h1);
    chk(!done_o, "R8 buffer write clears done", {255'b0, done_o}, 256'd0);
    d = rnd256();
    wport(24'h000060, d, o, e, v);
    chk(o == d && !e, "R8 cleared result not used", o, d);
    start_timed("R3 latency before addr clear");
    wreg(4'd8, 32'h000060);
    chk(!done_o, "R8 address write clears done", {255'b0, done_o}, 256'd0);
    wreg(4'd9, 32'd1);
    repeat (3) @(negedge clk);
    wreg(4'd0, 32'h5);
    repeat (10) @(negedge clk);
    chk(!done_o, "R8 write mid-operation cancels", {255'b0, done_o}, 256'd0);

    // R10 enable dropped after completion
    start_timed("R3 latency before enable drop");
    enc_en = 1'b0;
    d = rnd256();
    wport(24'h000060, d, o, e, v);
    chk(o == d && !e, "R10 enable low passes through", o, d);
    enc_en = 1'b1;

    summary();
    $finish;
  end
endmodule